// File: doc/BRIEF.md
# Multi-Chip Sync Substate Controller

This block steps one device through a multi-chip clock alignment procedure. While the device sits in its calibrated top-level state, a host issues a sync request. The block then moves the device clock onto the reference clock and reports that it is ready. It counts a train of external alignment pulses, moves the clock back onto the PLL after the fifth pulse and reports completion on the sixth. From there the host can advance the device to the primed state, or restart the procedure with a fresh request.

The request carries a power-saving level. Only level zero is supported; any other level is refused with an error flag. The alignment pulses arrive from outside the clock domain. They pass through a synchronizer and an edge detector, so each pulse counts exactly once. Once an alignment run has completed, a later return from primed to calibrated lands directly in the completed substate. Coordinating several devices is left to the host, which watches the ready flag of each one.

Top module: `msync_ctrl`

## Requirements
- R1: The synchronous active-low reset gives top_state=0 (calibrated; 1 means primed), sub_state=0, clk_sel=0 (PLL; 1 means reference), sync_ready=0, sync_err=0 and pulse_cnt=0. sub_state uses the codes Idle=0, Ready=1, Transition=2, Done=3.
- R2: A sync request with level zero in the calibrated state is accepted from any substate. On acceptance sub_state becomes Ready, clk_sel becomes 1, pulse_cnt becomes 0 and sync_err clears. This also restarts a run that is in Transition or Done.
- R3: A sync request is refused when the level is nonzero or when top_state is primed. A refusal sets sync_err and leaves top_state, sub_state, clk_sel and pulse_cnt unchanged. sync_err stays set until a request is accepted.
- R4: Each rising edge of the asynchronous pulse input, after a two-stage synchronizer, counts exactly once. The first counted pulse in Ready moves sub_state to Transition with pulse_cnt=1. sync_ready is 1 only in Ready.
- R5: The fifth counted pulse switches clk_sel from 1 (reference) to 0 (PLL). clk_sel stays 1 for pulses one to four.
- R6: The sixth counted pulse sets sub_state to Done with pulse_cnt=6.
- R7: Pulses are ignored in Idle, in Done, in the primed state and in any cycle that carries a command. Priority, highest first: sync request, go-to-primed, go-to-calibrated, pulse.
- R8: A go-to-primed request in the calibrated state moves top_state to 1 when sub_state is Idle or Done. It is ignored in Ready and in Transition.
- R9: A go-to-calibrated request in the primed state returns top_state to 0. sub_state becomes Done if any run has completed since reset, and Idle otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_req | input | 1 | One-cycle sync request strobe |
| sync_pwr_lvl | input | PWR_W | Power-saving level carried with the request |
| sync_pulse_in | input | 1 | Asynchronous external alignment pulse |
| prime_req | input | 1 | One-cycle go-to-primed strobe |
| calib_req | input | 1 | One-cycle go-to-calibrated strobe |
| top_state | output | 1 | 0 calibrated, 1 primed |
| sub_state | output | 2 | Idle=0, Ready=1, Transition=2, Done=3 |
| clk_sel | output | 1 | 0 PLL clock, 1 reference clock |
| sync_ready | output | 1 | High while in Ready |
| sync_err | output | 1 | Sticky refusal flag |
| pulse_cnt | output | CNT_W | Counted pulses of the current run |

## Verification
The hardest case to reach is the return from primed into Done. It needs a complete six-pulse run, then a go-to-primed request, then a go-to-calibrated request. The stimulus drives exactly that sequence. Before it, the bench makes an early primed round trip from Idle, before any run has completed, to show that the same request then lands in Idle. A restart in the middle of Transition and pulses sent in Done and in primed exercise the ignore paths. Each case is checked by observing pulse_cnt and sub_state.

// File: rtl/msync_pkg.sv
package msync_pkg;
   typedef enum logic [1:0] {
      SUB_IDLE  = 2'd0,
      SUB_READY = 2'd1,
      SUB_TRANS = 2'd2,
      SUB_DONE  = 2'd3
   } sub_e;

   typedef enum logic {
      TOP_CAL    = 1'b0,
      TOP_PRIMED = 1'b1
   } top_e;

   localparam logic CLK_PLL = 1'b0;
   localparam logic CLK_REF = 1'b1;
endpackage

// File: rtl/msync_pulse_in.sv
module msync_pulse_in #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("msync_pulse_in: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sq;
   logic              last_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) sq[0] <= 1'b0;
               else        sq[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) sq[g] <= 1'b0;
               else        sq[g] <= sq[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sq[STAGES-1];
   end

   assign rise = sq[STAGES-1] & ~last_q;

   // R4
   one_shot_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/msync_cmd_chk.sv
module msync_cmd_chk
   import msync_pkg::*;
#(
   parameter int PWR_W = 2
) (
   input  logic             sync_req,
   input  logic [PWR_W-1:0] pwr_lvl,
   input  top_e             top_q,
   output logic             accept,
   output logic             refuse
);
   generate
      if (PWR_W < 1) begin : g_bad
         $error("msync_cmd_chk: PWR_W must be at least 1");
      end
   endgenerate

   logic lvl_ok;
   logic state_ok;

   assign lvl_ok   = (pwr_lvl == '0);
   assign state_ok = (top_q == TOP_CAL);
   assign accept   = sync_req & lvl_ok & state_ok;
   assign refuse   = sync_req & ~(lvl_ok & state_ok);
endmodule

// File: rtl/msync_core.sv
module msync_core
   import msync_pkg::*;
#(
   parameter int N_SWITCH = 5,
   parameter int N_DONE   = 6,
   parameter int CNT_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_seen,
   input  logic             accept,
   input  logic             refuse,
   input  logic             prime_req,
   input  logic             calib_req,
   input  logic             rise,
   output top_e             top_q,
   output sub_e             sub_q,
   output logic             sel_q,
   output logic             err_q,
   output logic [CNT_W-1:0] cnt_q
);
   generate
      if (N_SWITCH < 1 || N_SWITCH >= N_DONE) begin : g_bad_order
         $error("msync_core: N_SWITCH must lie in 1..N_DONE-1");
      end
      if ((1 << CNT_W) <= N_DONE) begin : g_bad_width
         $error("msync_core: CNT_W too small for N_DONE");
      end
   endgenerate

   localparam logic [CNT_W-1:0] SW_CNT   = CNT_W'(N_SWITCH);
   localparam logic [CNT_W-1:0] DONE_CNT = CNT_W'(N_DONE);

   logic             en_q;
   logic             prime_ok;
   logic             calib_ok;
   logic             count_ok;
   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc  = cnt_q + 1'b1;
   assign prime_ok = prime_req && top_q == TOP_CAL &&
                     (sub_q == SUB_IDLE || sub_q == SUB_DONE);
   assign calib_ok = calib_req && top_q == TOP_PRIMED;
   assign count_ok = rise && !cmd_seen && top_q == TOP_CAL &&
                     (sub_q == SUB_READY || sub_q == SUB_TRANS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         top_q <= TOP_CAL;
         sub_q <= SUB_IDLE;
         sel_q <= CLK_PLL;
         err_q <= 1'b0;
         cnt_q <= '0;
         en_q  <= 1'b0;
      end else if (accept) begin
         sub_q <= SUB_READY;
         sel_q <= CLK_REF;
         err_q <= 1'b0;
         cnt_q <= '0;
      end else if (refuse) begin
         err_q <= 1'b1;
      end else if (prime_ok) begin
         top_q <= TOP_PRIMED;
      end else if (calib_ok) begin
         top_q <= TOP_CAL;
         sub_q <= en_q ? SUB_DONE : SUB_IDLE;
      end else if (count_ok) begin
         cnt_q <= cnt_inc;
         sub_q <= SUB_TRANS;
         if (cnt_inc == SW_CNT) sel_q <= CLK_PLL;
         if (cnt_inc == DONE_CNT) begin
            sub_q <= SUB_DONE;
            en_q  <= 1'b1;
         end
      end
   end

   // R2
   ready_on_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_q == SUB_READY) |-> (sel_q == CLK_REF));

   // R3
   refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      refuse |=> (err_q && $stable(top_q) && $stable(sub_q) && $stable(cnt_q)));

   // R5
   ref_before_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_q == SUB_TRANS && cnt_q < SW_CNT) |-> (sel_q == CLK_REF));

   // R6
   done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_q == SUB_DONE) |-> (cnt_q == DONE_CNT && sel_q == CLK_PLL));

   // R4
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count_ok && sub_q == SUB_TRANS) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R8
   prime_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (top_q == TOP_PRIMED && $past(top_q) == TOP_CAL) |->
      ($past(sub_q) == SUB_IDLE || $past(sub_q) == SUB_DONE));
endmodule

// File: rtl/msync_ctrl.sv
module msync_ctrl
   import msync_pkg::*;
#(
   parameter int PWR_W       = 2,
   parameter int SYNC_STAGES = 2,
   parameter int N_SWITCH    = 5,
   parameter int N_DONE      = 6,
   parameter int CNT_W       = $clog2(N_DONE + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_req,
   input  logic [PWR_W-1:0] sync_pwr_lvl,
   input  logic             sync_pulse_in,
   input  logic             prime_req,
   input  logic             calib_req,
   output logic             top_state,
   output logic [1:0]       sub_state,
   output logic             clk_sel,
   output logic             sync_ready,
   output logic             sync_err,
   output logic [CNT_W-1:0] pulse_cnt
);
   logic rise;
   logic accept;
   logic refuse;
   logic cmd_seen;
   top_e top_q;
   sub_e sub_q;

   msync_pulse_in #(.STAGES(SYNC_STAGES)) pulse_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (sync_pulse_in),
      .rise     (rise)
   );

   msync_cmd_chk #(.PWR_W(PWR_W)) cmd_i (
      .sync_req (sync_req),
      .pwr_lvl  (sync_pwr_lvl),
      .top_q    (top_q),
      .accept   (accept),
      .refuse   (refuse)
   );

   assign cmd_seen = sync_req | prime_req | calib_req;

   msync_core #(
      .N_SWITCH (N_SWITCH),
      .N_DONE   (N_DONE),
      .CNT_W    (CNT_W)
   ) core_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_seen  (cmd_seen),
      .accept    (accept),
      .refuse    (refuse),
      .prime_req (prime_req),
      .calib_req (calib_req),
      .rise      (rise),
      .top_q     (top_q),
      .sub_q     (sub_q),
      .sel_q     (clk_sel),
      .err_q     (sync_err),
      .cnt_q     (pulse_cnt)
   );

   assign top_state  = top_q;
   assign sub_state  = sub_q;
   assign sync_ready = (sub_q == SUB_READY);
endmodule

// File: tb/msync_ctrl_tb_top.sv
`timescale 1ns/1ps
module msync_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_req = 1'b0;
   logic [1:0] sync_pwr_lvl = 2'd0;
   logic       sync_pulse_in = 1'b0;
   logic       prime_req = 1'b0;
   logic       calib_req = 1'b0;
   logic       top_state;
   logic [1:0] sub_state;
   logic       clk_sel;
   logic       sync_ready;
   logic       sync_err;
   logic [2:0] pulse_cnt;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   logic [8:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;

   msync_ctrl dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .sync_req      (sync_req),
      .sync_pwr_lvl  (sync_pwr_lvl),
      .sync_pulse_in (sync_pulse_in),
      .prime_req     (prime_req),
      .calib_req     (calib_req),
      .top_state     (top_state),
      .sub_state     (sub_state),
      .clk_sel       (clk_sel),
      .sync_ready    (sync_ready),
      .sync_err      (sync_err),
      .pulse_cnt     (pulse_cnt)
   );

   // expected status vector: {top, sub[1:0], sel, ready, err, cnt[2:0]}
   function automatic logic [8:0] st(input logic t, input logic [1:0] s,
                                     input logic sel, input logic e,
                                     input logic [2:0] c);
      return {t, s, sel, (s == 2'd1), e, c};
   endfunction

   // monitor: pops expected items and compares at the falling edge
   always @(negedge clk) begin
      if (exp_q.size() != 0) begin
         logic [8:0] got;
         logic [8:0] exp;
         string      tag;
         got = {top_state, sub_state, clk_sel, sync_ready, sync_err, pulse_cnt};
         exp = exp_q.pop_front();
         tag = tag_q.pop_front();
         checks++;
         if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, got, exp);
         end
      end
   end

   task automatic expect_st(input logic [8:0] e, input string tag);
      @(negedge clk);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      wait (exp_q.size() == 0);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_sync(input logic [1:0] lvl);
      @(negedge clk);
      sync_req = 1'b1;
      sync_pwr_lvl = lvl;
      @(negedge clk);
      sync_req = 1'b0;
      sync_pwr_lvl = 2'd0;
      idle(1);
   endtask

   task automatic send_prime();
      @(negedge clk);
      prime_req = 1'b1;
      @(negedge clk);
      prime_req = 1'b0;
      idle(1);
   endtask

   task automatic send_calib();
      @(negedge clk);
      calib_req = 1'b1;
      @(negedge clk);
      calib_req = 1'b0;
      idle(1);
   endtask

   task automatic pulse();
      @(negedge clk);
      sync_pulse_in = 1'b1;
      idle(3);
      sync_pulse_in = 1'b0;
      idle(5);
   endtask

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      expect_st(st(0, 2'd0, 0, 0, 3'd0), "R1 reset state");

      pulse();
      expect_st(st(0, 2'd0, 0, 0, 3'd0), "R7 pulse in Idle ignored");

      send_prime();
      expect_st(st(1, 2'd0, 0, 0, 3'd0), "R8 prime from Idle");
      send_sync(2'd0);
      expect_st(st(1, 2'd0, 0, 1, 3'd0), "R3 request in primed refused");
      pulse();
      expect_st(st(1, 2'd0, 0, 1, 3'd0), "R7 pulse in primed ignored");
      send_calib();
      expect_st(st(0, 2'd0, 0, 1, 3'd0), "R9 calib before any run gives Idle");

      send_sync(2'd2);
      expect_st(st(0, 2'd0, 0, 1, 3'd0), "R3 nonzero level refused");

      send_sync(2'd0);
      expect_st(st(0, 2'd1, 1, 0, 3'd0), "R2 accept enters Ready");
      send_prime();
      expect_st(st(0, 2'd1, 1, 0, 3'd0), "R8 prime ignored in Ready");

      pulse();
      expect_st(st(0, 2'd2, 1, 0, 3'd1), "R4 first pulse to Transition");
      for (int i = 2; i <= 4; i++) begin
         pulse();
         expect_st(st(0, 2'd2, 1, 0, 3'(i)), "R4 count step, R5 ref kept");
      end
      pulse();
      expect_st(st(0, 2'd2, 0, 0, 3'd5), "R5 fifth pulse selects PLL");
      pulse();
      expect_st(st(0, 2'd3, 0, 0, 3'd6), "R6 sixth pulse gives Done");
      pulse();
      expect_st(st(0, 2'd3, 0, 0, 3'd6), "R7 pulse in Done ignored");

      send_sync(2'd0);
      expect_st(st(0, 2'd1, 1, 0, 3'd0), "R2 restart from Done");
      pulse();
      pulse();
      expect_st(st(0, 2'd2, 1, 0, 3'd2), "R4 partial run");
      send_prime();
      expect_st(st(0, 2'd2, 1, 0, 3'd2), "R8 prime ignored in Transition");
      send_sync(2'd3);
      expect_st(st(0, 2'd2, 1, 1, 3'd2), "R3 refusal keeps Transition");
      send_sync(2'd0);
      expect_st(st(0, 2'd1, 1, 0, 3'd0), "R2 restart from Transition");
      for (int i = 0; i < 6; i++) pulse();
      expect_st(st(0, 2'd3, 0, 0, 3'd6), "R6 second run Done");

      send_prime();
      expect_st(st(1, 2'd3, 0, 0, 3'd6), "R8 prime from Done");
      send_calib();
      expect_st(st(0, 2'd3, 0, 0, 3'd6), "R9 calib returns to Done");

      // pulse rising in the same cycle as a command is dropped
      send_sync(2'd0);
      @(negedge clk);
      sync_pulse_in = 1'b1;
      idle(2);
      sync_req = 1'b1;
      @(negedge clk);
      sync_req = 1'b0;
      idle(2);
      sync_pulse_in = 1'b0;
      idle(5);
      expect_st(st(0, 2'd1, 1, 0, 3'd0), "R7 pulse in command cycle dropped");

      pulse();
      expect_st(st(0, 2'd2, 1, 0, 3'd1), "R4 pulse after drop counted");
      @(negedge clk);
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      expect_st(st(0, 2'd0, 0, 0, 3'd0), "R1 reset mid-run");

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule